// File: doc/BRIEF.md
# Dual-Mode Stream Accelerator Controller

This block sequences a streaming feature-extraction core that has a single 32-bit input stream and a single 32-bit output stream. A `start` pulse, taken together with `mode_sel`, decides what the next stream words mean. In load mode (`mode_sel`=0), each accepted word goes into the on-chip parameter memory. Words are written in arrival order, beginning at address 0. When `param_count` words have arrived, the controller sends one nonzero acknowledge word and raises `params_loaded`.

In extract mode (`mode_sel`=1), the controller first clears the global feature registers to zero. Every three accepted words then form one point, in the order x, y, z. Each complete point is passed to a compute pipeline. The hardware places no limit on the number of points. The last point is marked by `s_tlast` on its z word. The controller then waits until the pipeline reports that it is empty, and only then streams out the `NFEAT` global feature words. The final feature word carries `m_tlast`. If `s_tlast` arrives on an x or y word, the run is abandoned and an error flag is raised.

The compute pipeline here is a stub. It adds the three signed coordinates, delays the sum by `PIPE_LAT` cycles, and then, for each feature k, forms the candidate `sum + param[k]`. Each global feature keeps the signed maximum of its candidates. Because the features start at zero, a feature whose candidates are all negative reads 0.

States: S_IDLE (ready, waiting for start), S_LOAD (storing parameters), S_ACK (acknowledge word on the output), S_CLEAR (one cycle to zero the features), S_GATHER (collecting coordinates), S_DRAIN (waiting for the pipeline to empty), S_EMIT (streaming features). Transitions:
- IDLE→LOAD on start with mode 0 and a nonzero count.
- IDLE→ACK on start with mode 0 and a zero count.
- IDLE→CLEAR on start with mode 1.
- LOAD→ACK when the final counted word is accepted.
- ACK→IDLE when the acknowledge handshake completes.
- CLEAR→GATHER unconditionally after one cycle.
- GATHER→DRAIN when tlast arrives on a z word.
- GATHER→IDLE when tlast arrives on an x or y word.
- DRAIN→EMIT when the pipeline reports empty.
- EMIT→IDLE when the handshake on the last feature word completes.

Top module: `stream_mode_ctrl`

## Requirements
- R1: After reset, `s_tready`, `m_tvalid`, `params_loaded` and `tlast_err` are all 0.
- R2: In load mode, the n-th accepted word (counting from 0) is stored at parameter address n. Feature k uses address k.
- R3: After `param_count` words are accepted, exactly one word equal to `ACK_WORD` (default 32'hA5A5_0001, nonzero) appears on the output with `m_tlast`=1. `params_loaded` is 1 once that word has been taken.
- R4: Every extract run starts from features equal to zero. A feature whose candidates are all negative is output as 0, even if an earlier run left it positive.
- R5: Input words are grouped as x, y, z. Output feature k equals the maximum of 0 and, over all points, the signed 32-bit value x+y+z+param[k].
- R6: Any number of points is accepted. A run ends on `s_tlast` with a z word, and no output word is valid until the final point has drained from the pipeline.
- R7: `s_tlast` on an x or y word sets `tlast_err`, returns the block to idle (`s_tready`=0), and produces no output. The next `start` clears `tlast_err`.
- R8: A word is consumed only when `s_tvalid` and `s_tready` are both 1. `s_tready` is 0 outside loading and gathering.
- R9: While `m_tvalid` is 1 and `m_tready` is 0, `m_tdata` and `m_tlast` hold their values. Feature words come out in index order 0..NFEAT-1, and `m_tlast` is 1 only on the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run (taken only in idle) |
| mode_sel | input | 1 | 0 = load parameters, 1 = extract features |
| param_count | input | CW | Number of parameter words to load |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Input word accepted this cycle if valid |
| s_tdata | input | DW | Input word (signed fixed point) |
| s_tlast | input | 1 | Marks the z word of the last point |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | DW | Acknowledge word or feature word |
| m_tlast | output | 1 | Last word of an output burst |
| params_loaded | output | 1 | A parameter load has been acknowledged |
| tlast_err | output | 1 | A misplaced tlast aborted the last run |

## Verification
The assertions assume that `start` arrives only while the block is idle, and that `param_count` and `mode_sel` are stable when it does. They also assume that the upstream source keeps a word valid until it is accepted. The bench drives its inputs only on falling edges. It pulses `start` only after the previous run has finished, either with its last output handshake or with an error return to idle. It keeps `s_tvalid` asserted until a rising edge at which `s_tready` was high. Gaps between words and stalls on `m_tready` are inserted to exercise holding of the stream under back-pressure.

// File: rtl/smc_pkg.sv
package smc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_ACK,
        S_CLEAR,
        S_GATHER,
        S_DRAIN,
        S_EMIT
    } smc_state_t;
endpackage

// File: rtl/smc_param_mem.sv
module smc_param_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 12,
    parameter int NRD   = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DW-1:0]     wdata,
    output logic [NRD*DW-1:0] rd_flat
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        if (k < DEPTH) begin : g_have
            assign rd_flat[k*DW +: DW] = mem[k];
        end else begin : g_none
            assign rd_flat[k*DW +: DW] = '0;
        end
    end

    // R2: a written word lands at the address it was sent to
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/smc_point_pipe.sv
module smc_point_pipe #(
    parameter int DW  = 32,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic [DW-1:0] z,
    output logic          out_valid,
    output logic [DW-1:0] out_sum,
    output logic          drained
);
    logic [LAT-1:0] vld;
    logic [DW-1:0]  sum [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld    <= '0;
            sum[0] <= '0;
        end else begin
            vld[0] <= in_valid;
            if (in_valid) sum[0] <= x + y + z;
        end
    end

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[s] <= 1'b0;
                sum[s] <= '0;
            end else begin
                vld[s] <= vld[s-1];
                sum[s] <= sum[s-1];
            end
        end
    end

    assign out_valid = vld[LAT-1];
    assign out_sum   = sum[LAT-1];
    assign drained   = ~|vld;

    // R6: a point just issued means the pipeline is not empty
    assert_inflight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !drained);
endmodule

// File: rtl/smc_feature_max.sv
module smc_feature_max #(
    parameter int DW    = 32,
    parameter int NFEAT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                upd,
    input  logic [DW-1:0]       sum,
    input  logic [NFEAT*DW-1:0] w_flat,
    output logic [NFEAT*DW-1:0] g_flat
);
    for (genvar k = 0; k < NFEAT; k++) begin : g_feat
        logic signed [DW-1:0] cand;
        logic signed [DW-1:0] cur;
        assign cand = $signed(sum) + $signed(w_flat[k*DW +: DW]);
        assign cur  = $signed(g_flat[k*DW +: DW]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                g_flat[k*DW +: DW] <= '0;
            end else if (clr) begin
                g_flat[k*DW +: DW] <= '0;
            end else if (upd && (cand > cur)) begin
                g_flat[k*DW +: DW] <= cand;
            end
        end
    end

    // R4: a clear leaves every feature at zero
    assert_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> g_flat == '0);
endmodule

// File: rtl/stream_mode_ctrl.sv
module stream_mode_ctrl
    import smc_pkg::*;
#(
    parameter int          DW       = 32,
    parameter int          CW       = 16,
    parameter int          DEPTH    = 12,
    parameter int          NFEAT    = 4,
    parameter int          PIPE_LAT = 3,
    parameter logic [31:0] ACK_WORD = 32'hA5A5_0001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_sel,
    input  logic [CW-1:0] param_count,
    input  logic          s_tvalid,
    output logic          s_tready,
    input  logic [DW-1:0] s_tdata,
    input  logic          s_tlast,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic [DW-1:0] m_tdata,
    output logic          m_tlast,
    output logic          params_loaded,
    output logic          tlast_err
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int EIW = (NFEAT > 1) ? $clog2(NFEAT) : 1;

    smc_state_t state, nxt;

    logic [CW-1:0]  wr_ptr, target;
    logic [1:0]     coord;
    logic [EIW-1:0] emit_idx;
    logic [DW-1:0]  xr, yr;
    logic           accept, m_hs, pt_valid, mem_we, load_done, bad_last;
    logic           pipe_out_v, drained;
    logic [DW-1:0]  pipe_sum;
    logic [NFEAT*DW-1:0] w_flat, g_flat;

    assign accept    = s_tvalid && s_tready;
    assign m_hs      = m_tvalid && m_tready;
    assign load_done = accept && (state == S_LOAD) && (wr_ptr == target - 1'b1);
    assign bad_last  = accept && (state == S_GATHER) && s_tlast && (coord != 2'd2);
    assign pt_valid  = accept && (state == S_GATHER) && (coord == 2'd2);
    assign mem_we    = accept && (state == S_LOAD) && (wr_ptr < CW'(DEPTH));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (mode_sel)               nxt = S_CLEAR;
                    else if (param_count == '0) nxt = S_ACK;
                    else                        nxt = S_LOAD;
                end
            end
            S_LOAD:   if (load_done) nxt = S_ACK;
            S_ACK:    if (m_hs) nxt = S_IDLE;
            S_CLEAR:  nxt = S_GATHER;
            S_GATHER: begin
                if (bad_last)                 nxt = S_IDLE;
                else if (pt_valid && s_tlast) nxt = S_DRAIN;
            end
            S_DRAIN:  if (drained) nxt = S_EMIT;
            S_EMIT:   if (m_hs && (emit_idx == EIW'(NFEAT - 1))) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_tready = 1'b0;
        m_tvalid = 1'b0;
        m_tdata  = '0;
        m_tlast  = 1'b0;
        unique case (state)
            S_LOAD, S_GATHER: s_tready = 1'b1;
            S_ACK: begin
                m_tvalid = 1'b1;
                m_tdata  = DW'(ACK_WORD);
                m_tlast  = 1'b1;
            end
            S_EMIT: begin
                m_tvalid = 1'b1;
                m_tdata  = g_flat[emit_idx*DW +: DW];
                m_tlast  = (emit_idx == EIW'(NFEAT - 1));
            end
            default: ;
        endcase
    end

    // counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr        <= '0;
            target        <= '0;
            coord         <= '0;
            emit_idx      <= '0;
            xr            <= '0;
            yr            <= '0;
            params_loaded <= 1'b0;
            tlast_err     <= 1'b0;
        end else begin
            if (state == S_IDLE && start) begin
                wr_ptr    <= '0;
                target    <= param_count;
                coord     <= '0;
                emit_idx  <= '0;
                tlast_err <= 1'b0;
                if (!mode_sel) params_loaded <= 1'b0;
            end
            if (accept && state == S_LOAD) wr_ptr <= wr_ptr + 1'b1;
            if (accept && state == S_GATHER) begin
                if (coord == 2'd0) xr <= s_tdata;
                if (coord == 2'd1) yr <= s_tdata;
                coord <= (coord == 2'd2) ? 2'd0 : coord + 2'd1;
            end
            if (bad_last) tlast_err <= 1'b1;
            if (state == S_ACK && m_hs) params_loaded <= 1'b1;
            if (state == S_EMIT && m_hs) emit_idx <= emit_idx + 1'b1;
        end
    end

    smc_param_mem #(.DW(DW), .DEPTH(DEPTH), .NRD(NFEAT)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we),
        .waddr(AW'(wr_ptr)), .wdata(s_tdata), .rd_flat(w_flat)
    );

    smc_point_pipe #(.DW(DW), .LAT(PIPE_LAT)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(pt_valid),
        .x(xr), .y(yr), .z(s_tdata),
        .out_valid(pipe_out_v), .out_sum(pipe_sum), .drained(drained)
    );

    smc_feature_max #(.DW(DW), .NFEAT(NFEAT)) u_feat (
        .clk(clk), .rst_n(rst_n), .clr(state == S_CLEAR), .upd(pipe_out_v),
        .sum(pipe_sum), .w_flat(w_flat), .g_flat(g_flat)
    );

    // R9: output word held while stalled
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R6: streaming of features begins only once the pipeline was empty
    assert_emit_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EMIT && $past(state) != S_EMIT) |-> $past(drained));

    // R7: error flag rises only after a tlast word was taken
    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tlast_err) |-> $past(accept && s_tlast));

    // R8: nothing consumed while not ready
    assert_no_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_LOAD && state != S_GATHER) |-> !s_tready);
endmodule

// File: tb/stream_mode_ctrl_tb.sv
module stream_mode_ctrl_tb;
    localparam int NFEAT = 4;
    localparam logic [31:0] ACKW = 32'hA5A5_0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode_sel = 1'b0;
    logic [15:0] param_count = '0;
    logic s_tvalid = 1'b0, s_tlast = 1'b0, m_tready = 1'b0;
    logic [31:0] s_tdata = '0;
    logic s_tready, m_tvalid, m_tlast, params_loaded, tlast_err;
    logic [31:0] m_tdata;

    int checks = 0, fails = 0;
    bit done = 0;
    int wm [12];
    int px [4], py [4], pz [4];

    always #10 clk = ~clk;

    stream_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
        .param_count(param_count), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tdata(s_tdata), .s_tlast(s_tlast), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
        .params_loaded(params_loaded), .tlast_err(tlast_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start(logic m, int cnt);
        mode_sel = m; param_count = 16'(cnt); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic send(logic [31:0] d, logic l, int gap);
        s_tvalid = 1'b1; s_tdata = d; s_tlast = l;
        while (!s_tready) @(negedge clk);
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic recv(output logic [31:0] d, output logic l, input int stall);
        m_tready = 1'b0;
        while (!m_tvalid) @(negedge clk);
        d = m_tdata; l = m_tlast;
        repeat (stall) begin
            @(negedge clk);
            check("R9 hold data", m_tdata, d);
            check("R9 hold last", 32'(m_tlast), 32'(l));
        end
        m_tready = 1'b1;
        @(negedge clk);
        m_tready = 1'b0;
    endtask

    task automatic do_load(int n, string req);
        logic [31:0] d; logic l;
        pulse_start(1'b0, n);
        for (int i = 0; i < n; i++) begin
            send(32'(wm[i]), 1'b0, i % 2);
            if (i < n - 1) check({req, " no output during load"}, 32'(m_tvalid), 0);
        end
        recv(d, l, 2);
        check("R3 ack word", d, ACKW);
        check("R3 ack last", 32'(l), 1);
        check("R3 loaded flag", 32'(params_loaded), 1);
        check("R3 single ack", 32'(m_tvalid), 0);
    endtask

    task automatic do_extract(int np, string req);
        logic [31:0] d; logic l; int e;
        pulse_start(1'b1, 0);
        for (int i = 0; i < np; i++) begin
            send(32'(px[i]), 1'b0, 0);
            send(32'(py[i]), 1'b0, i % 2);
            send(32'(pz[i]), i == np - 1, 0);
            check("R6 no result before end", 32'(m_tvalid), 0);
        end
        check("R8 not ready after last point", 32'(s_tready), 0);
        for (int k = 0; k < NFEAT; k++) begin
            e = 0;
            for (int i = 0; i < np; i++)
                if (px[i] + py[i] + pz[i] + wm[k] > e) e = px[i] + py[i] + pz[i] + wm[k];
            recv(d, l, (k == 1) ? 3 : 0);
            check(req, d, 32'(e));
            check("R9 tlast position", 32'(l), 32'(k == NFEAT - 1));
        end
        @(negedge clk);
        check("R9 burst ends", 32'(m_tvalid), 0);
    endtask

    task automatic t_reset;
        check("R1 s_tready", 32'(s_tready), 0);
        check("R1 m_tvalid", 32'(m_tvalid), 0);
        check("R1 loaded", 32'(params_loaded), 0);
        check("R1 err", 32'(tlast_err), 0);
    endtask

    task automatic t_backpressure_in;
        // R8: valid held low while ready: block stays waiting, nothing taken
        pulse_start(1'b0, 4);
        repeat (3) @(negedge clk);
        check("R8 waits for valid", 32'(s_tready), 1);
        wm[0] = 5; wm[1] = -3; wm[2] = 100; wm[3] = -7;
        for (int i = 0; i < 4; i++) send(32'(wm[i]), 1'b0, 1);
        begin
            logic [31:0] d; logic l;
            recv(d, l, 0);
            check("R8 ack after exactly 4 words", d, ACKW);
        end
    endtask

    task automatic t_error;
        pulse_start(1'b1, 0);
        send(32'd1, 1'b0, 0);
        send(32'd2, 1'b1, 0);
        check("R7 err set", 32'(tlast_err), 1);
        check("R7 idle after err", 32'(s_tready), 0);
        repeat (8) @(negedge clk);
        check("R7 no output", 32'(m_tvalid), 0);
        pulse_start(1'b1, 0);
        check("R7 err cleared by start", 32'(tlast_err), 0);
        send(32'd0, 1'b0, 0); send(32'd0, 1'b0, 0); send(32'd0, 1'b1, 0);
        begin
            logic [31:0] d; logic l;
            for (int k = 0; k < NFEAT; k++) recv(d, l, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_backpressure_in();
        // R5: two points, mixed signs
        px[0] = 1;   py[0] = 2; pz[0] = 3;
        px[1] = -10; py[1] = 0; pz[1] = 4;
        do_extract(2, "R5 feature value");
        // R4: all candidates negative after a positive run
        px[0] = -100; py[0] = -100; pz[0] = -100;
        do_extract(1, "R4 cleared start");
        // R6: four points
        px[0] = 7; py[0] = -1; pz[0] = 0;
        px[1] = 3; py[1] = 3;  pz[1] = 3;
        px[2] = -50; py[2] = 20; pz[2] = 1;
        px[3] = 0; py[3] = 0;  pz[3] = -4;
        do_extract(4, "R6 many points");
        t_error();
        // R2: reload with six words, check address order via zero point
        wm[0] = 7; wm[1] = -2; wm[2] = 0; wm[3] = 9; wm[4] = 55; wm[5] = 66;
        do_load(6, "R2");
        px[0] = 0; py[0] = 0; pz[0] = 0;
        do_extract(1, "R2 stored order");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule